// File: doc/BRIEF.md
# Edge-Count Command Decoder for a Serial Display Driver

This block sits behind the serial port of a multi-channel constant-current display driver. Commands do not arrive as opcode bits. A command is the number of serial-clock rising edges seen while the latch-enable line is held high. The final edge of a 24-bit data load may itself be one of those edges. When latch-enable falls, the block turns the accumulated count into one action. It can strobe the shifted word into the output latches, store it as the configuration or gain word, reload the shift register with a stored word or a thermal status word, or arm one of the LED fault checks.

The block runs on one system clock. The serial clock reaches it as a one-cycle `tick` strobe, so the port logic is assumed to be synchronised beforehand. The block owns the 24-bit shift register and shifts `sdi` in at its least significant end. The most significant bit drives `sdo`, which lets a reloaded word leave MSB first on the following 24 ticks. The configuration word is also decoded into its named control fields for the rest of the chip.

Top module: `ledk_key_decoder`

## Requirements
- R1: After reset the configuration word is all zeros and the gain word is 0x03FFFF (three 6-bit fields of all ones in bits 17:0, bits 23:18 zero). `sdo` is 0 and no strobe is high.
- R2: On every cycle with `tick` high, the shift register moves one place toward its MSB and `sdi` enters bit 0. `shift_word` shows the register and `sdo` equals its bit 23.
- R3: Ticks are counted only while `le` is high. The command executes on the first clock that samples `le` low after it was high, and its effect is visible after that edge. A count of 1 or 2 raises `latch_pulse` for exactly one cycle.
- R4: A count of 3 or 4 stores shift register bits 11:0 into the configuration word. Bits 23:12 of the configuration word always read as zero.
- R5: A count of 7 or 8 stores shift register bits 17:0 into the gain word (red 5:0, green 11:6, blue 17:12). Bits 23:18 always read as zero.
- R6: A count of 5 or 6 loads the configuration word into the shift register, and a count of 9 or 10 loads the gain word. The stored value then appears on `sdo` MSB first over the next 24 ticks.
- R7: A count of 11 pulses `open_arm` alone, 12 pulses `short_arm` alone, and 13 pulses both, each for one cycle.
- R8: A count of 14 loads 24 ones into the shift register if `therm_alert` is high on the executing cycle, and 24 zeros otherwise.
- R9: Counts of 0, 15, 16 and anything above 16 change no stored word, raise no strobe and do not reload the shift register.
- R10: Configuration fields are decoded as follows. `range_sel` is bits 2:0 (red at bit 0). `short_sel` is bits 5:3. `auto_off` is bit 6, `sdo_half` is bit 7 and `stagger_off` is bit 8. `colour_order` is bits 11:9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe marking a serial-clock rising edge |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Latch-enable level |
| therm_alert | input | 1 | Over-temperature alert level |
| sdo | output | 1 | Serial data out, shift register MSB |
| shift_word | output | 24 | Shift register contents |
| latch_pulse | output | 1 | Data-latch strobe |
| open_arm | output | 1 | Open-circuit check arm pulse |
| short_arm | output | 1 | Short-circuit check arm pulse |
| cfg_word | output | 24 | Stored configuration word |
| gain_word | output | 24 | Stored gain word |
| range_sel | output | 3 | Per-colour current range select |
| short_sel | output | 3 | Per-colour short threshold select |
| auto_off | output | 1 | Auto power-off enable |
| sdo_half | output | 1 | Falling-edge output shift select |
| stagger_off | output | 1 | Staggered turn-on disable |
| colour_order | output | 3 | Colour order code |

## Verification
The bench builds the block with its default parameters: a 24-bit word, three colours, 6-bit gain fields and a 5-bit saturating edge counter. The counter reaches 31, so counts above 16 are reachable and can be shown to be ignored, as are both reserved counts. Because the word is a full 24 bits, read-back can be compared bit by bit and the masked upper bits of both stored words can be observed.

// File: rtl/ledk_pkg.sv
package ledk_pkg;

    typedef enum logic [3:0] {
        K_NONE,
        K_LATCH,
        K_WCFG,
        K_RCFG,
        K_WGAIN,
        K_RGAIN,
        K_OPEN,
        K_SHORT,
        K_BOTH,
        K_THERM,
        K_RSVD
    } key_e;

    // Fixed table: number of edges seen with latch-enable high -> action.
    function automatic key_e key_of(input int n);
        key_e k;
        case (n)
            1, 2:    k = K_LATCH;
            3, 4:    k = K_WCFG;
            5, 6:    k = K_RCFG;
            7, 8:    k = K_WGAIN;
            9, 10:   k = K_RGAIN;
            11:      k = K_OPEN;
            12:      k = K_SHORT;
            13:      k = K_BOTH;
            14:      k = K_THERM;
            15, 16:  k = K_RSVD;
            default: k = K_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ledk_key_counter.sv
module ledk_key_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             le,
    output logic [CNT_W-1:0] count,
    output logic             fall
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             le;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        fall    = st_q.le & ~le;
        st_d.le = le;
        if (fall) begin
            st_d.cnt = '0;
        end else if (le && tick && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/ledk_reg_bank.sv
module ledk_reg_bank #(
    parameter int WORD_W   = 24,
    parameter int COLOURS  = 3,
    parameter int GAIN_W   = 6,
    parameter int CFG_USED = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cfg,
    input  logic              wr_gain,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] cfg_word,
    output logic [WORD_W-1:0] gain_word
);
    localparam int GAIN_BITS = COLOURS * GAIN_W;

    typedef struct packed {
        logic [CFG_USED-1:0]             cfg;
        logic [COLOURS-1:0][GAIN_W-1:0]  gain;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_cfg) begin
            st_d.cfg = din[CFG_USED-1:0];
        end
        if (wr_gain) begin
            for (int c = 0; c < COLOURS; c++) begin
                st_d.gain[c] = din[c*GAIN_W +: GAIN_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= '0;
            for (int c = 0; c < COLOURS; c++) begin
                st_q.gain[c] <= {GAIN_W{1'b1}};
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_word  = {{(WORD_W-CFG_USED){1'b0}}, st_q.cfg};
    assign gain_word = {{(WORD_W-GAIN_BITS){1'b0}}, st_q.gain};

endmodule

// File: rtl/ledk_key_decoder.sv
module ledk_key_decoder #(
    parameter int WORD_W  = 24,
    parameter int COLOURS = 3,
    parameter int GAIN_W  = 6,
    parameter int ORDER_W = 3,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               sdi,
    input  logic               le,
    input  logic               therm_alert,
    output logic               sdo,
    output logic [WORD_W-1:0]  shift_word,
    output logic               latch_pulse,
    output logic               open_arm,
    output logic               short_arm,
    output logic [WORD_W-1:0]  cfg_word,
    output logic [WORD_W-1:0]  gain_word,
    output logic [COLOURS-1:0] range_sel,
    output logic [COLOURS-1:0] short_sel,
    output logic               auto_off,
    output logic               sdo_half,
    output logic               stagger_off,
    output logic [ORDER_W-1:0] colour_order
);
    import ledk_pkg::*;

    // Field placement inside the configuration word.
    localparam int SHORT_LO = COLOURS;
    localparam int AUTO_BIT = 2 * COLOURS;
    localparam int HALF_BIT = AUTO_BIT + 1;
    localparam int STAG_BIT = AUTO_BIT + 2;
    localparam int ORD_LO   = AUTO_BIT + 3;
    localparam int CFG_USED = ORD_LO + ORDER_W;

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic              latch;
        logic              open;
        logic              short;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic [CNT_W-1:0] edge_cnt;
    logic             le_fall;
    key_e             key;
    logic             wr_cfg, wr_gain;

    ledk_key_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .le    (le),
        .count (edge_cnt),
        .fall  (le_fall)
    );

    ledk_reg_bank #(
        .WORD_W   (WORD_W),
        .COLOURS  (COLOURS),
        .GAIN_W   (GAIN_W),
        .CFG_USED (CFG_USED)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cfg    (wr_cfg),
        .wr_gain   (wr_gain),
        .din       (st_q.sr),
        .cfg_word  (cfg_word),
        .gain_word (gain_word)
    );

    always_comb begin
        key        = le_fall ? key_of(int'(edge_cnt)) : K_NONE;
        st_d       = st_q;
        st_d.latch = 1'b0;
        st_d.open  = 1'b0;
        st_d.short = 1'b0;
        wr_cfg     = 1'b0;
        wr_gain    = 1'b0;
        if (tick) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], sdi};
        end
        case (key)
            K_LATCH: st_d.latch = 1'b1;
            K_WCFG:  wr_cfg     = 1'b1;
            K_RCFG:  st_d.sr    = cfg_word;
            K_WGAIN: wr_gain    = 1'b1;
            K_RGAIN: st_d.sr    = gain_word;
            K_OPEN:  st_d.open  = 1'b1;
            K_SHORT: st_d.short = 1'b1;
            K_BOTH: begin
                st_d.open  = 1'b1;
                st_d.short = 1'b1;
            end
            K_THERM: st_d.sr    = {WORD_W{therm_alert}};
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo         = st_q.sr[WORD_W-1];
    assign shift_word  = st_q.sr;
    assign latch_pulse = st_q.latch;
    assign open_arm    = st_q.open;
    assign short_arm   = st_q.short;

    // Per-colour control bits come from two parallel lanes of the word.
    for (genvar c = 0; c < COLOURS; c++) begin : g_lane
        assign range_sel[c] = cfg_word[c];
        assign short_sel[c] = cfg_word[SHORT_LO + c];
    end

    assign auto_off     = cfg_word[AUTO_BIT];
    assign sdo_half     = cfg_word[HALF_BIT];
    assign stagger_off  = cfg_word[STAG_BIT];
    assign colour_order = cfg_word[ORD_LO +: ORDER_W];

endmodule

// File: rtl/ledk_key_checker.sv
module ledk_key_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        le,
    input logic        latch_pulse,
    input logic        open_arm,
    input logic        short_arm,
    input logic [23:0] cfg_word,
    input logic [23:0] gain_word
);
    p_latch_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_pulse |=> !latch_pulse);

    p_strobe_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({latch_pulse, open_arm | short_arm}));

    p_cfg_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_word[23:12] == 12'h000);

    p_gain_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gain_word[23:18] == 6'h00);

    p_cfg_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(le, 2) && !$past(le)) |-> $stable(cfg_word));

    p_gain_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(le, 2) && !$past(le)) |-> $stable(gain_word));

    p_arm_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (open_arm || short_arm) |-> ($past(le, 2) && !$past(le)));
endmodule

bind ledk_key_decoder ledk_key_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .le          (le),
    .latch_pulse (latch_pulse),
    .open_arm    (open_arm),
    .short_arm   (short_arm),
    .cfg_word    (cfg_word),
    .gain_word   (gain_word)
);

// File: tb/ledk_key_decoder_test.sv
module ledk_key_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, sdi = 1'b0, le = 1'b0, therm_alert = 1'b0;
    logic        sdo, latch_pulse, open_arm, short_arm;
    logic        auto_off, sdo_half, stagger_off;
    logic [23:0] shift_word, cfg_word, gain_word;
    logic [2:0]  range_sel, short_sel, colour_order;

    int vectors = 0;
    int miscompares = 0;
    int n_latch = 0, n_open = 0, n_short = 0;
    logic [23:0] latched_seen = '0;
    bit done = 0;

    always #5 clk = ~clk;

    ledk_key_decoder uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sdi(sdi), .le(le),
        .therm_alert(therm_alert), .sdo(sdo), .shift_word(shift_word),
        .latch_pulse(latch_pulse), .open_arm(open_arm), .short_arm(short_arm),
        .cfg_word(cfg_word), .gain_word(gain_word), .range_sel(range_sel),
        .short_sel(short_sel), .auto_off(auto_off), .sdo_half(sdo_half),
        .stagger_off(stagger_off), .colour_order(colour_order)
    );

    // Behavioural reference, updated on each rising edge.
    int          m_cnt;
    bit          m_le, m_lat, m_op, m_sh;
    logic [23:0] m_sr, m_cfg, m_gain;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_le = 0; m_lat = 0; m_op = 0; m_sh = 0;
            m_sr = 0; m_cfg = 0; m_gain = 24'h03FFFF;
        end else begin
            bit fall;
            logic [23:0] nsr;
            fall = m_le && !le;
            m_lat = 0; m_op = 0; m_sh = 0;
            nsr = tick ? {m_sr[22:0], sdi} : m_sr;
            if (fall) begin
                if (m_cnt == 1 || m_cnt == 2) m_lat = 1;
                else if (m_cnt == 3 || m_cnt == 4) m_cfg = m_sr & 24'h000FFF;
                else if (m_cnt == 5 || m_cnt == 6) nsr = m_cfg;
                else if (m_cnt == 7 || m_cnt == 8) m_gain = m_sr & 24'h03FFFF;
                else if (m_cnt == 9 || m_cnt == 10) nsr = m_gain;
                else if (m_cnt == 11) m_op = 1;
                else if (m_cnt == 12) m_sh = 1;
                else if (m_cnt == 13) begin m_op = 1; m_sh = 1; end
                else if (m_cnt == 14) nsr = therm_alert ? 24'hFFFFFF : 24'h0;
            end
            m_sr = nsr;
            if (fall) m_cnt = 0;
            else if (le && tick && m_cnt < 31) m_cnt++;
            m_le = le;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Every-cycle comparison against the reference, plus strobe counters.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2", "sdo", {23'b0, sdo}, {23'b0, m_sr[23]});
            check("R2", "shift_word", shift_word, m_sr);
            check("R4", "cfg_word", cfg_word, m_cfg);
            check("R5", "gain_word", gain_word, m_gain);
            check("R3", "latch_pulse", {23'b0, latch_pulse}, {23'b0, m_lat});
            check("R7", "arms", {22'b0, open_arm, short_arm}, {22'b0, m_op, m_sh});
            check("R10", "fields",
                  {range_sel, short_sel, auto_off, sdo_half, stagger_off, colour_order},
                  {m_cfg[2:0], m_cfg[5:3], m_cfg[6], m_cfg[7], m_cfg[8], m_cfg[11:9]});
            if (latch_pulse) begin n_latch++; latched_seen = shift_word; end
            if (open_arm) n_open++;
            if (short_arm) n_short++;
        end
    end

    task automatic step(input bit l, input bit t, input bit d);
        @(negedge clk);
        le = l; tick = t; sdi = d;
    endtask

    // Shift a word MSB first with le high on the last nkey ticks.
    task automatic send(input logic [23:0] w, input int nkey);
        for (int i = 23; i >= 0; i--) step(i < nkey, 1'b1, w[i]);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
    endtask

    // Key with no data, then collect 24 bits from sdo.
    task automatic read_key(input int n, output logic [23:0] w);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        for (int i = 23; i >= 0; i--) begin
            @(negedge clk);
            w[i] = sdo;
            tick = 1'b1;
        end
        step(1'b0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : stim
        logic [23:0] w;
        int pl, po, ps;
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1", "reset cfg", cfg_word, 24'h0);
        check("R1", "reset gain", gain_word, 24'h03FFFF);
        check("R1", "reset sdo", {23'b0, sdo}, 24'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2/R3 data latch with 1 and 2 edges
        send(24'h123456, 1);
        check("R3", "latch count k1", n_latch, 1);
        check("R2", "latched word k1", latched_seen, 24'h123456);
        send(24'h9A5C3F, 2);
        check("R3", "latch count k2", n_latch, 2);
        check("R2", "latched word k2", latched_seen, 24'h9A5C3F);

        // R4/R10 configuration writes
        send(24'hABC5A5, 3);
        check("R4", "cfg write k3", cfg_word, 24'h0005A5);
        check("R10", "range_sel", range_sel, 3'b101);
        check("R10", "colour_order", colour_order, 3'd2);
        send(24'hFFF2C0, 4);
        check("R4", "cfg write k4", cfg_word, 24'h0002C0);
        check("R10", "auto_off", auto_off, 1'b1);
        check("R10", "stagger_off", stagger_off, 1'b0);

        // R5 gain writes
        send(24'hFEDCBA, 7);
        check("R5", "gain write k7", gain_word, 24'h02DCBA);
        send(24'h00F00F, 8);
        check("R5", "gain write k8", gain_word, 24'h00F00F);

        // R6 read-back
        read_key(5, w);  check("R6", "cfg read k5", w, 24'h0002C0);
        read_key(6, w);  check("R6", "cfg read k6", w, 24'h0002C0);
        read_key(9, w);  check("R6", "gain read k9", w, 24'h00F00F);
        read_key(10, w); check("R6", "gain read k10", w, 24'h00F00F);

        // R7 detection arms
        read_key(11, w);
        check("R7", "open only", {n_open[15:0], n_short[15:0]} , 32'h00010000);
        read_key(12, w);
        check("R7", "short only", {n_open[15:0], n_short[15:0]}, 32'h00010001);
        read_key(13, w);
        check("R7", "both", {n_open[15:0], n_short[15:0]}, 32'h00020002);

        // R8 thermal status word
        therm_alert = 1'b1;
        read_key(14, w); check("R8", "thermal alert", w, 24'hFFFFFF);
        therm_alert = 1'b0;
        read_key(14, w); check("R8", "thermal clear", w, 24'h000000);

        // R9 ignored counts
        pl = n_latch; po = n_open; ps = n_short;
        send(24'h5A5A5A, 15);
        check("R9", "k15 no reload", shift_word, 24'h5A5A5A);
        send(24'hC3C3C3, 16);
        check("R9", "k16 no reload", shift_word, 24'hC3C3C3);
        send(24'h777777, 20);
        check("R9", "k20 no reload", shift_word, 24'h777777);
        send(24'h0F0F0F, 0);
        check("R9", "k0 no reload", shift_word, 24'h0F0F0F);
        check("R9", "cfg kept", cfg_word, 24'h0002C0);
        check("R9", "gain kept", gain_word, 24'h00F00F);
        check("R9", "no strobes", n_latch + n_open + n_short, pl + po + ps);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule